// File: doc/BRIEF.md
# Lane-Partitioned Unsigned Comparator

This block compares two unsigned operands of equal width that are cut into 8-bit lanes. A vector of split bits, one per boundary between neighbouring lanes, is set at runtime. It decides whether two neighbours act as separate elements or as parts of one wider element. One datapath can therefore compare many narrow values at once, or fewer wide ones, or a mix of both.

A 2-bit operation select chooses equality, unsigned greater-than or unsigned greater-or-equal. The result vector has one bit per lane. Every element, whether a single lane or a run of joined lanes, reports one result bit in its most significant lane. All lower lanes of that element read zero. The block is purely combinational: results follow the inputs with no clock.

Top module: `simdLaneCompare`

## Requirements
- R1: Lane i occupies operand bits [8i+7:8i]. laneSplit[i]=1 separates lane i from lane i+1, which is the boundary at bit 8(i+1). laneSplit[i]=0 joins those two lanes into one element.
- R2: opSel encodes the operation: 2'b00 is equality, 2'b01 is unsigned greater-than (opA > opB), and 2'b10 is unsigned greater-or-equal (opA >= opB).
- R3: When every split bit is 1, cmpOut[i] is the selected comparison of lane i of opA against lane i of opB.
- R4: When every split bit is 0, the full operands are compared as one value. The result is on cmpOut[NUM_LANES-1] and every other output bit is 0.
- R5: An element made of joined lanes is compared as the concatenation of its lanes, with the higher lane most significant. Its result appears on the element's top lane.
- R6: For every operation, the output bit of any lane that is not the top lane of its element is 0.
- R7: For opSel 2'b11, all output bits are 0.
- R8: Under greater-or-equal, an element's result is 1 exactly when its greater-than result or its equality result is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | NUM_LANES*8 | First operand |
| opB | input | NUM_LANES*8 | Second operand |
| opSel | input | 2 | Operation select |
| laneSplit | input | NUM_LANES-1 | Boundary split bits, one per lane boundary |
| cmpOut | output | NUM_LANES | Result bit per lane, valid in each element's top lane |

## Verification
Immediate assertions are evaluated whenever the inputs change. They check that the operation strobes are at most one-hot, that no lane reports greater and equal together, that lanes below an element's top read zero, that the reserved code clears the output, and that the unsplit case matches a full-width compare. The bench covers what those checks cannot show. It sweeps every split pattern under every operation code, using random, identical and single-bit-different operands. Each result is compared with a model that slices the operands by the split bits. This is how the concatenation order and the greater-or-equal composition are shown correct.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  typedef enum logic [1:0] {
    OP_EQ   = 2'b00,
    OP_GT   = 2'b01,
    OP_GE   = 2'b10,
    OP_RSVD = 2'b11
  } cmpOp_e;

  typedef struct packed {
    logic doEq;
    logic doGt;
    logic doGe;
  } cmpStrobe_t;
endpackage

// File: rtl/simd_cmp_ctrl.sv
module simd_cmp_ctrl
  import simd_cmp_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [1:0]           opSel,
  input  logic [NUM_LANES-2:0] laneSplit,
  output cmpStrobe_t           strobe,
  output logic [NUM_LANES-1:0] topMask,
  output logic [NUM_LANES-1:0] chainEn
);
  cmpOp_e opDec;

  always_comb begin
    opDec  = cmpOp_e'(opSel);
    strobe = '0;
    unique case (opDec)
      OP_EQ:   strobe.doEq = 1'b1;
      OP_GT:   strobe.doGt = 1'b1;
      OP_GE:   strobe.doGe = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_comb begin
    assert_strobe_onehot_R2: assert ($onehot0({strobe.doEq, strobe.doGt, strobe.doGe}))
      else $error("strobes not one-hot");
    assert_rsvd_idle_R7: assert (opSel != 2'b11 || strobe == '0)
      else $error("reserved code raised a strobe");
  end

  // The top lane always closes an element; lane 0 never chains from below.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : gLaneCtl
      if (gi == NUM_LANES - 1) begin : gTop
        assign topMask[gi] = 1'b1;
      end else begin : gMid
        assign topMask[gi] = laneSplit[gi];
      end
      if (gi == 0) begin : gBase
        assign chainEn[gi] = 1'b0;
      end else begin : gLink
        assign chainEn[gi] = ~laneSplit[gi-1];
      end
    end
  endgenerate
endmodule

// File: rtl/simd_cmp_lane.sv
module simd_cmp_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] aLane,
  input  logic [LANE_W-1:0] bLane,
  input  logic              chainEn,
  input  logic              eqBelow,
  input  logic              gtBelow,
  output logic              eqRun,
  output logic              gtRun
);
  logic eqLocal;
  logic gtLocal;

  always_comb begin
    eqLocal = (aLane == bLane);
    gtLocal = (aLane > bLane);
    // This lane is more significant than the chained part below it.
    if (chainEn) begin
      eqRun = eqLocal & eqBelow;
      gtRun = gtLocal | (eqLocal & gtBelow);
    end else begin
      eqRun = eqLocal;
      gtRun = gtLocal;
    end
  end

  always_comb begin
    assert_eq_gt_exclusive_R5: assert (!(eqRun && gtRun))
      else $error("lane reports greater and equal together");
  end
endmodule

// File: rtl/simd_cmp_datapath.sv
module simd_cmp_datapath
  import simd_cmp_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  cmpStrobe_t           strobe,
  input  logic [NUM_LANES-1:0] topMask,
  input  logic [NUM_LANES-1:0] chainEn,
  output logic [NUM_LANES-1:0] laneRes
);
  logic [NUM_LANES-1:0] eqRun;
  logic [NUM_LANES-1:0] gtRun;
  logic [NUM_LANES-1:0] rawSel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : gLane
      logic eqIn;
      logic gtIn;
      if (gi == 0) begin : gFirst
        assign eqIn = 1'b1;
        assign gtIn = 1'b0;
      end else begin : gRest
        assign eqIn = eqRun[gi-1];
        assign gtIn = gtRun[gi-1];
      end
      simd_cmp_lane #(.LANE_W(LANE_W)) laneCell_i (
        .aLane   (opA[gi*LANE_W +: LANE_W]),
        .bLane   (opB[gi*LANE_W +: LANE_W]),
        .chainEn (chainEn[gi]),
        .eqBelow (eqIn),
        .gtBelow (gtIn),
        .eqRun   (eqRun[gi]),
        .gtRun   (gtRun[gi])
      );
      assign rawSel[gi] = (strobe.doEq & eqRun[gi])
                        | (strobe.doGt & gtRun[gi])
                        | (strobe.doGe & (gtRun[gi] | eqRun[gi]));
    end
  endgenerate

  assign laneRes = rawSel & topMask;
endmodule

// File: rtl/simdLaneCompare.sv
module simdLaneCompare
  import simd_cmp_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  logic [1:0]           opSel,
  input  logic [NUM_LANES-2:0] laneSplit,
  output logic [NUM_LANES-1:0] cmpOut
);
  cmpStrobe_t           strobe;
  logic [NUM_LANES-1:0] topMask;
  logic [NUM_LANES-1:0] chainEn;

  simd_cmp_ctrl #(.NUM_LANES(NUM_LANES)) ctrl_i (
    .opSel     (opSel),
    .laneSplit (laneSplit),
    .strobe    (strobe),
    .topMask   (topMask),
    .chainEn   (chainEn)
  );

  simd_cmp_datapath #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .topMask (topMask),
    .chainEn (chainEn),
    .laneRes (cmpOut)
  );

  always_comb begin
    assert_lower_lanes_zero_R6: assert ((cmpOut[NUM_LANES-2:0] & ~laneSplit) == '0)
      else $error("non-top lane of an element is set");
    assert_rsvd_zero_R7: assert (opSel != 2'b11 || cmpOut == '0)
      else $error("reserved code produced a result");
    assert_whole_eq_R4: assert (!(laneSplit == '0 && opSel == 2'b00)
                                || cmpOut[NUM_LANES-1] == (opA == opB))
      else $error("full-width equality mismatch");
    assert_whole_gt_R4: assert (!(laneSplit == '0 && opSel == 2'b01)
                                || cmpOut[NUM_LANES-1] == (opA > opB))
      else $error("full-width greater-than mismatch");
  end
endmodule

// File: tb/simdLaneCompare_tb_top.sv
module simdLaneCompare_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int DW = NL * LW;
  localparam int WATCHDOG_CYCLES = 100000;

  typedef struct {
    logic [NL-1:0] expOut;
    logic [NL-1:0] topMask;
    string         tag;
  } sbItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [1:0] opSel = 2'b00;
  logic [NL-2:0] laneSplit = '0;
  logic [NL-1:0] cmpOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  sbItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simdLaneCompare #(.NUM_LANES(NL), .LANE_W(LW)) dut_i (
    .opA(opA), .opB(opB), .opSel(opSel), .laneSplit(laneSplit), .cmpOut(cmpOut)
  );

  // Reference: slice operands into elements by the split bits (R1, R5).
  function automatic logic [NL-1:0] refModel(logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [1:0] op, logic [NL-2:0] sp);
    logic [NL-1:0] r = '0;
    int start = 0;
    for (int i = 0; i < NL; i++) begin
      if (i == NL-1 || sp[i]) begin
        int wid = (i - start + 1) * LW;
        logic [DW-1:0] ga = a >> (start * LW);
        logic [DW-1:0] gb = b >> (start * LW);
        logic [DW-1:0] msk = {DW{1'b1}} >> (DW - wid);
        ga &= msk;
        gb &= msk;
        case (op)
          2'b00: r[i] = (ga == gb);
          2'b01: r[i] = (ga > gb);
          2'b10: r[i] = (ga >= gb);
          default: r[i] = 1'b0;
        endcase
        start = i + 1;
      end
    end
    return r;
  endfunction

  function automatic logic [NL-1:0] topOf(logic [NL-2:0] sp);
    return {1'b1, sp};
  endfunction

  task automatic driveVec(logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] op,
                          logic [NL-2:0] sp, string tag);
    sbItem_t it;
    @(negedge clk);
    opA = a; opB = b; opSel = op; laneSplit = sp;
    it.expOut = refModel(a, b, op, sp);
    it.topMask = topOf(sp);
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  function automatic string tagFor(logic [1:0] op, logic [NL-2:0] sp);
    string t;
    if (op == 2'b11) t = "R7";
    else if (sp == '1) t = "R3";
    else if (sp == '0) t = "R4";
    else t = "R1 R5";
    if (op == 2'b10) t = {t, " R8"};
    if (op != 2'b11) t = {t, " R2"};
    return t;
  endfunction

  // Monitor: pops one expected item per rising edge.
  always @(posedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      sbItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (cmpOut !== it.expOut) begin
        errors++;
        $display("FAIL %s: cmpOut=%b expected=%b", it.tag, cmpOut, it.expOut);
      end
      checks++;
      if ((cmpOut & ~it.topMask) !== '0) begin
        errors++;
        $display("FAIL R6: cmpOut=%b expected lanes outside %b to be 0",
                 cmpOut, it.topMask);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG_CYCLES) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Idle inputs: all lanes joined, equal operands (R4).
    driveVec('0, '0, 2'b00, '0, "R4 reset");
    // Directed concatenation order: upper lane dominates (R5).
    driveVec(32'h0100_00FF, 32'h0001_FF00, 2'b01, 3'b011, "R5 order");
    driveVec(32'h0000_00FF, 32'h0000_0100, 2'b10, 3'b000, "R4 R8 carry");
    for (int sp = 0; sp < (1 << (NL-1)); sp++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 24; k++) begin
          logic [DW-1:0] a = $urandom;
          logic [DW-1:0] b;
          if (k % 3 == 0) b = a;
          else if (k % 3 == 1) b = a ^ (DW'(1) << ($urandom % DW));
          else b = $urandom;
          driveVec(a, b, 2'(op), (NL-1)'(sp), tagFor(2'(op), (NL-1)'(sp)));
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule